// File: doc/BRIEF.md
# Boot strap and clock select unit

This unit sits beside the system clock tree. It runs on a fast reference clock that stands for a 192 MHz PLL output. On the first clock edge after reset is released it records a set of board straps, once: the reference crystal frequency code, the boot chip-select choice, the width of the boot bus and the host transport choice. It holds that record until the next reset. Any strap code that is not allowed raises a flag that stays set, and the recorded value falls back to a safe setting.

From the fast clock the unit makes two single-cycle clock enables. The CPU enable divides the fast clock by 6, 12, 24 or 48, which gives 32, 16, 8 or 4 MHz. The radio tick divides it by 192, which gives 1 MHz. Each enable can come instead from an external clock pin, through a synchronizer and a rising-edge detector. Two straps choose the sources at boot. A control-register write can later override both sources and sets the CPU divide selection. A new divide ratio waits for the end of the CPU period already running.

Top module: `boot_clk_unit`

## Requirements
- R1: While reset is asserted, and until the strap capture, `cpu_en` and `bt_tick` are 0. While reset is asserted, `boot_ref`, `boot_from_cs0`, `boot_bank16`, `boot_hci_usb`, `sys_ext_sel`, `tx_ext_sel`, `div_sel` and `strap_err` are all 0.
- R2: The straps are captured on the first rising clock edge with `rst_n` high. Later changes on the strap inputs leave every `boot_*` output unchanged until the next reset.
- R3: `boot_ref` takes the value of `strap_ref` when that value is 00 (12 MHz), 01 (13 MHz) or 10 (16 MHz). Code 11 is forbidden and is recorded as 00.
- R4: On `strap_remap`, 10 gives `boot_from_cs0`=0 (boot from chip select 1) and 11 gives `boot_from_cs0`=1. Codes 00 and 01 are forbidden and give `boot_from_cs0`=1.
- R5: `boot_bank16` records `strap_bank16` (0 = 8-bit, 1 = 16-bit boot bus). `boot_hci_usb` records `strap_hci_usb` (0 = UART, 1 = USB).
- R6: `strap_err` goes to 1 at capture if the reference or remap code is forbidden, and stays 1 until reset. It stays 0 for allowed codes.
- R7: With the internal CPU source, `cpu_en` is a one-cycle pulse every 6 << `div_sel` fast cycles (`div_sel` 0..3 gives 6/12/24/48). `div_sel` is 0 after reset.
- R8: After a divide write, the CPU period already running keeps its old length. The following periods use the new ratio.
- R9: With the internal radio source, `bt_tick` is a one-cycle pulse every 192 fast cycles.
- R10: With `sys_ext_sel`=1, `cpu_en` gives exactly one one-cycle pulse for each rising edge of `usr_clk`, and no internal pulses.
- R11: With `tx_ext_sel`=1, `bt_tick` gives exactly one one-cycle pulse for each rising edge of `ext_txclk`, and no internal pulses.
- R12: A cycle with `ctl_we`=1 loads `ctl_div`, `ctl_sys_ext` and `ctl_tx_ext`. From the next cycle on, these set `div_sel`, `sys_ext_sel` and `tx_ext_sel` and replace the strap-chosen sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock (192 MHz PLL output) |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ref | input | 2 | Reference frequency strap code |
| strap_sys_ext | input | 1 | CPU clock source strap, 1 = external user clock |
| strap_tx_ext | input | 1 | Radio clock source strap, 1 = external transmit clock |
| strap_remap | input | 2 | Boot chip-select strap code |
| strap_bank16 | input | 1 | Boot bus width strap |
| strap_hci_usb | input | 1 | Host transport strap |
| usr_clk | input | 1 | External user clock, asynchronous |
| ext_txclk | input | 1 | External 1 MHz transmit clock, asynchronous |
| ctl_we | input | 1 | Control register write strobe |
| ctl_div | input | 2 | Written CPU divide selection |
| ctl_sys_ext | input | 1 | Written CPU source selection |
| ctl_tx_ext | input | 1 | Written radio source selection |
| cpu_en | output | 1 | CPU clock enable pulse |
| bt_tick | output | 1 | 1 MHz radio tick pulse |
| boot_ref | output | 2 | Recorded reference frequency code |
| boot_from_cs0 | output | 1 | Boot from chip select 0 when 1 |
| boot_bank16 | output | 1 | Recorded boot bus width |
| boot_hci_usb | output | 1 | Recorded host transport |
| sys_ext_sel | output | 1 | CPU source in effect |
| tx_ext_sel | output | 1 | Radio source in effect |
| div_sel | output | 2 | CPU divide selection in effect |
| strap_err | output | 1 | Sticky forbidden-strap flag |

## Verification
The bench records boots with each forbidden code, on its own and together with the other. A unit that decoded forbidden codes literally would report reference code 11 or boot from chip select 1, or would leave the error flag clear. It writes a new divide ratio directly after a CPU pulse. A unit that switched ratio straight away would cut short the period already running instead of finishing it at the old length. With external sources selected it counts pulses against the exact number of edges driven. Internal pulses leaking through, or an edge detector firing on levels, would push the count above the number of edges. It also moves the straps after boot, and a unit that kept sampling them would change its recorded outputs.

// File: rtl/boot_clk_pkg.sv
package boot_clk_pkg;

  typedef struct packed {
    logic [1:0] ref_code;
    logic       from_cs0;
    logic       bank16;
    logic       hci_usb;
    logic       sys_ext;
    logic       tx_ext;
    logic       err;
  } boot_cfg_t;

  // CPU period in fast cycles for a divide selection
  function automatic int unsigned div_ratio(input int unsigned base, input logic [1:0] sel);
    return base << sel;
  endfunction

  function automatic logic ref_forbidden(input logic [1:0] code);
    return code == 2'b11;
  endfunction

  // remap codes with the upper bit clear are not allowed
  function automatic logic remap_forbidden(input logic [1:0] code);
    return ~code[1];
  endfunction

endpackage

// File: rtl/bcu_strap_latch.sv
module bcu_strap_latch
  import boot_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_ref,
  input  logic       strap_sys_ext,
  input  logic       strap_tx_ext,
  input  logic [1:0] strap_remap,
  input  logic       strap_bank16,
  input  logic       strap_hci_usb,
  output boot_cfg_t  cfg,
  output logic       captured
);
  boot_cfg_t cfg_d;

  always_comb begin
    cfg_d.ref_code = ref_forbidden(strap_ref) ? 2'b00 : strap_ref;
    cfg_d.from_cs0 = remap_forbidden(strap_remap) ? 1'b1 : strap_remap[0];
    cfg_d.bank16   = strap_bank16;
    cfg_d.hci_usb  = strap_hci_usb;
    cfg_d.sys_ext  = strap_sys_ext;
    cfg_d.tx_ext   = strap_tx_ext;
    cfg_d.err      = ref_forbidden(strap_ref) | remap_forbidden(strap_remap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      captured <= 1'b0;
    end else if (!captured) begin
      cfg      <= cfg_d;
      captured <= 1'b1;
    end
  end
endmodule

// File: rtl/bcu_rate_div.sv
module bcu_rate_div #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_LIM = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] lim_req,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             wrap;

  assign wrap = (cnt == lim);
  assign tick = run & wrap;

  // a requested limit is taken only when the running period wraps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= CNT_W'(RST_LIM);
    end else if (run) begin
      if (wrap) begin
        cnt <= '0;
        lim <= lim_req;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcu_edge_tick.sv
module bcu_edge_tick #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic tick
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], raw};
  end

  assign tick = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/boot_clk_unit.sv
module boot_clk_unit
  import boot_clk_pkg::*;
#(
  parameter int unsigned BASE_DIV    = 6,
  parameter int unsigned BT_DIV      = 192,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_ref,
  input  logic       strap_sys_ext,
  input  logic       strap_tx_ext,
  input  logic [1:0] strap_remap,
  input  logic       strap_bank16,
  input  logic       strap_hci_usb,
  input  logic       usr_clk,
  input  logic       ext_txclk,
  input  logic       ctl_we,
  input  logic [1:0] ctl_div,
  input  logic       ctl_sys_ext,
  input  logic       ctl_tx_ext,
  output logic       cpu_en,
  output logic       bt_tick,
  output logic [1:0] boot_ref,
  output logic       boot_from_cs0,
  output logic       boot_bank16,
  output logic       boot_hci_usb,
  output logic       sys_ext_sel,
  output logic       tx_ext_sel,
  output logic [1:0] div_sel,
  output logic       strap_err
);
  localparam int unsigned CPU_MAX = BASE_DIV << 3;
  localparam int unsigned TOP_DIV = (BT_DIV > CPU_MAX) ? BT_DIV : CPU_MAX;
  localparam int unsigned CNT_W   = $clog2(TOP_DIV);

  boot_cfg_t        cfg;
  logic             captured;
  logic             ovr_q;
  logic [1:0]       div_q;
  logic             sys_q, tx_q;
  logic [CNT_W-1:0] cpu_lim;
  logic             int_cpu_tick, int_bt_tick, usr_tick, txc_tick;

  bcu_strap_latch u_latch (
    .clk, .rst_n, .strap_ref, .strap_sys_ext, .strap_tx_ext,
    .strap_remap, .strap_bank16, .strap_hci_usb,
    .cfg(cfg), .captured(captured)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      div_q <= 2'b00;
      sys_q <= 1'b0;
      tx_q  <= 1'b0;
    end else if (ctl_we) begin
      ovr_q <= 1'b1;
      div_q <= ctl_div;
      sys_q <= ctl_sys_ext;
      tx_q  <= ctl_tx_ext;
    end
  end

  assign div_sel     = div_q;
  assign sys_ext_sel = ovr_q ? sys_q : cfg.sys_ext;
  assign tx_ext_sel  = ovr_q ? tx_q  : cfg.tx_ext;
  assign cpu_lim     = CNT_W'(div_ratio(BASE_DIV, div_q) - 1);

  bcu_rate_div #(.CNT_W(CNT_W), .RST_LIM(BASE_DIV - 1)) u_cpu_div (
    .clk, .rst_n, .run(captured), .lim_req(cpu_lim), .tick(int_cpu_tick)
  );

  bcu_rate_div #(.CNT_W(CNT_W), .RST_LIM(BT_DIV - 1)) u_bt_div (
    .clk, .rst_n, .run(captured), .lim_req(CNT_W'(BT_DIV - 1)), .tick(int_bt_tick)
  );

  bcu_edge_tick #(.STAGES(SYNC_STAGES)) u_usr_edge (
    .clk, .rst_n, .raw(usr_clk), .tick(usr_tick)
  );

  bcu_edge_tick #(.STAGES(SYNC_STAGES)) u_txc_edge (
    .clk, .rst_n, .raw(ext_txclk), .tick(txc_tick)
  );

  assign cpu_en  = captured & (sys_ext_sel ? usr_tick : int_cpu_tick);
  assign bt_tick = captured & (tx_ext_sel ? txc_tick : int_bt_tick);

  assign boot_ref      = cfg.ref_code;
  assign boot_from_cs0 = cfg.from_cs0;
  assign boot_bank16   = cfg.bank16;
  assign boot_hci_usb  = cfg.hci_usb;
  assign strap_err     = cfg.err;
endmodule

// File: rtl/boot_clk_unit_chk.sv
module boot_clk_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       captured,
  input logic       cpu_en,
  input logic       bt_tick,
  input logic [1:0] boot_ref,
  input logic       boot_from_cs0,
  input logic       boot_bank16,
  input logic       boot_hci_usb,
  input logic       strap_err
);
  a_r1_quiet_until_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !captured |-> (!cpu_en && !bt_tick));

  a_r2_boot_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && $past(captured)) |->
      ($stable(boot_ref) && $stable(boot_from_cs0) && $stable(boot_bank16) && $stable(boot_hci_usb)));

  a_r3_ref_never_forbidden: assert property (@(posedge clk) disable iff (!rst_n)
    captured |-> (boot_ref != 2'b11));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_err) |-> strap_err);

  a_r7_cpu_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |=> !cpu_en);

  a_r9_bt_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bt_tick |=> !bt_tick);
endmodule

bind boot_clk_unit boot_clk_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .captured(captured), .cpu_en(cpu_en), .bt_tick(bt_tick),
  .boot_ref(boot_ref), .boot_from_cs0(boot_from_cs0), .boot_bank16(boot_bank16),
  .boot_hci_usb(boot_hci_usb), .strap_err(strap_err)
);

// File: tb/tb_boot_clk_unit.sv
module tb_boot_clk_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap_ref = 2'b00, strap_remap = 2'b11;
  logic       strap_sys_ext = 0, strap_tx_ext = 0, strap_bank16 = 0, strap_hci_usb = 0;
  logic       usr_clk = 0, ext_txclk = 0;
  logic       ctl_we = 0, ctl_sys_ext = 0, ctl_tx_ext = 0;
  logic [1:0] ctl_div = 2'b00;
  logic       cpu_en, bt_tick, boot_from_cs0, boot_bank16, boot_hci_usb;
  logic       sys_ext_sel, tx_ext_sel, strap_err;
  logic [1:0] boot_ref, div_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  boot_clk_unit dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_boot(input logic [1:0] rf, input logic sx, input logic tx,
                         input logic [1:0] rm, input logic b16, input logic hu);
    @(negedge clk);
    rst_n = 0; ctl_we = 0; usr_clk = 0; ext_txclk = 0;
    strap_ref = rf; strap_sys_ext = sx; strap_tx_ext = tx;
    strap_remap = rm; strap_bank16 = b16; strap_hci_usb = hu;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outputs in reset", int'({cpu_en, bt_tick, boot_ref, boot_from_cs0, boot_bank16,
          boot_hci_usb, sys_ext_sel, tx_ext_sel, div_sel, strap_err}), 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_cpu();
    for (int i = 0; i < 300 && !cpu_en; i++) @(negedge clk);
  endtask

  task automatic wait_bt();
    for (int i = 0; i < 300 && !bt_tick; i++) @(negedge clk);
  endtask

  // called while cpu_en is high; returns cycles to next pulse
  task automatic cpu_period(output int p);
    p = 0;
    do begin @(negedge clk); p++; ctl_we = 0; end while (!cpu_en && p < 300);
  endtask

  task automatic bt_period(output int p);
    p = 0;
    do begin @(negedge clk); p++; end while (!bt_tick && p < 400);
  endtask

  task automatic t_capture_and_hold();
    do_boot(2'b10, 0, 0, 2'b10, 1, 1);
    check("R3 ref 16MHz code", int'(boot_ref), 2);
    check("R4 remap 10 boots cs1", int'(boot_from_cs0), 0);
    check("R5 bank16", int'(boot_bank16), 1);
    check("R5 hci usb", int'(boot_hci_usb), 1);
    check("R6 no err clean straps", int'(strap_err), 0);
    strap_ref = 2'b01; strap_remap = 2'b11; strap_bank16 = 0; strap_hci_usb = 0;
    repeat (5) @(negedge clk);
    check("R2 straps held", int'({boot_ref, boot_from_cs0, boot_bank16, boot_hci_usb}), 6'b10_0_1_1);
  endtask

  task automatic t_cpu_ratios();
    int p;
    check("R7 div_sel reset", int'(div_sel), 0);
    wait_cpu();
    @(negedge clk);
    check("R7 pulse width", int'(cpu_en), 0);
    wait_cpu(); cpu_period(p);
    check("R7 period 6", p, 6);
    for (int s = 1; s < 4; s++) begin
      int old_p, new_p;
      old_p = 6 << (s - 1);
      wait_cpu();
      ctl_we = 1; ctl_div = 2'(s); ctl_sys_ext = 0; ctl_tx_ext = 0;
      cpu_period(p);
      check("R8 running period keeps old ratio", p, old_p);
      cpu_period(new_p);
      check("R7 new ratio period", new_p, 6 << s);
      check("R12 div_sel", int'(div_sel), s);
    end
  endtask

  task automatic t_bt_tick();
    int p;
    wait_bt(); bt_period(p);
    check("R9 bt period 192", p, 192);
    bt_period(p);
    check("R9 bt period repeat", p, 192);
  endtask

  task automatic t_forbidden();
    do_boot(2'b11, 0, 0, 2'b01, 0, 0);
    check("R3 ref 11 falls back", int'(boot_ref), 0);
    check("R4 remap 01 to cs0", int'(boot_from_cs0), 1);
    check("R6 err set", int'(strap_err), 1);
    strap_ref = 2'b00; strap_remap = 2'b11;
    repeat (4) @(negedge clk);
    check("R6 err sticky", int'(strap_err), 1);
    do_boot(2'b01, 0, 0, 2'b00, 0, 0);
    check("R3 ref 13MHz", int'(boot_ref), 1);
    check("R4 remap 00 to cs0", int'(boot_from_cs0), 1);
    check("R6 err remap only", int'(strap_err), 1);
    do_boot(2'b00, 0, 0, 2'b11, 0, 0);
    check("R4 remap 11 cs0", int'(boot_from_cs0), 1);
    check("R6 err clear", int'(strap_err), 0);
    check("R5 bank8 uart", int'({boot_bank16, boot_hci_usb}), 0);
  endtask

  task automatic t_external_and_override();
    int nc = 0, nb = 0, p;
    do_boot(2'b00, 1, 1, 2'b11, 0, 0);
    check("R10 sys ext selected", int'(sys_ext_sel), 1);
    check("R11 tx ext selected", int'(tx_ext_sel), 1);
    fork
      repeat (20) begin
        usr_clk = 1; repeat (4) @(negedge clk);
        usr_clk = 0; repeat (4) @(negedge clk);
      end
      repeat (8) begin
        ext_txclk = 1; repeat (10) @(negedge clk);
        ext_txclk = 0; repeat (10) @(negedge clk);
      end
      repeat (170) begin
        @(negedge clk);
        if (cpu_en) nc++;
        if (bt_tick) nb++;
      end
    join
    check("R10 cpu pulses per usr edge", nc, 20);
    check("R11 bt pulses per ext edge", nb, 8);
    ctl_we = 1; ctl_div = 2'b00; ctl_sys_ext = 0; ctl_tx_ext = 0;
    @(negedge clk); ctl_we = 0;
    check("R12 override sources", int'({sys_ext_sel, tx_ext_sel}), 0);
    wait_cpu(); cpu_period(p);
    check("R12 internal cpu after override", p, 6);
    wait_bt(); bt_period(p);
    check("R12 internal bt after override", p, 192);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_capture_and_hold();
    t_cpu_ratios();
    t_bt_tick();
    t_forbidden();
    t_external_and_override();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule